// File: doc/BRIEF.md
# Frame and Line Qualified Pixel Capture

This block sits directly behind an 8-bit parallel image sensor and runs on the pixel clock the sensor supplies. It samples the frame-valid and line-valid qualifiers together with the pixel byte on every clock. It produces an output byte, with a strobe, only for samples taken while both qualifiers are high. Blanking samples are dropped, including the idle value 0x10 that the sensor drives between lines and frames. Any sync words the sensor embeds while its line qualifier is high pass through unchanged.

Capture is enabled by a level input. When that input rises while a frame is already in progress (either qualifier high), the block does not join the frame part-way. It waits until both qualifiers are low and starts at the next frame. Each frame's first emitted byte carries a frame-start pulse, and each line's last emitted byte carries a line-end pulse. The line end is known one sample early because the inputs pass through two register stages before the capture decision is made. Every captured byte reaches the output two clock edges after the edge that sampled it.

Top module: `pix_gate_capture`

## Requirements
- R1: While reset is asserted, `pix_vld`, `sof_pulse`, `eol_pulse` and `pix_out` are all 0.
- R2: A byte is emitted only when the frame and line qualifiers were both high in the same sample. Samples with either qualifier low, including 0x10 blanking, never produce `pix_vld`.
- R3: With `cap_en` high and the block waiting for a frame, each byte sampled at clock edge k with both qualifiers high appears on `pix_out` with `pix_vld` high after edge k+2. Bytes keep their order and none is lost, for every line count, line length and line gap of one or more samples.
- R4: If `cap_en` rises while either qualifier is high, nothing is emitted from that frame. Capture begins with the first frame that starts after both qualifiers have been low.
- R5: `sof_pulse` is high together with `pix_vld` on the first emitted byte of each frame, and on no other byte.
- R6: `eol_pulse` is high together with `pix_vld` on the last emitted byte of each line, meaning the byte whose following sample has either qualifier low. A one-byte line carries both pulses.
- R7: While `cap_en` is low, no byte is emitted whatever the qualifiers do.
- R8: When the frame and line qualifiers rise in the same sample, the first byte of that line is still captured, with `sof_pulse`.
- R9: If the frame qualifier falls while the line qualifier stays high, capture stops at the last sample with both high and that byte carries `eol_pulse`. The following frame is captured normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Sensor pixel clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Level enable for capture |
| fval_in | input | 1 | Frame qualifier from the sensor |
| lval_in | input | 1 | Line qualifier from the sensor |
| pix_in | input | 8 | Pixel byte from the sensor |
| pix_out | output | 8 | Captured byte |
| pix_vld | output | 1 | Strobe marking a captured byte on `pix_out` |
| sof_pulse | output | 1 | First byte of a frame |
| eol_pulse | output | 1 | Last byte of a line |

## Verification
A state machine stuck in a waiting state shows up as missing strobes two edges after the first byte of a line. Entering capture too early shows up as strobes on blanking samples, or as a frame joined part-way after a late enable. A wrong lookahead tap moves the line-end pulse one byte off, and this is visible on the first line. Because every expected byte is tied to the exact cycle it should appear in, a latency error of a single stage is caught on the first captured byte.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [2:0] {
    SEEK_OFF   = 3'd0,
    SEEK_DRAIN = 3'd1,
    SEEK_FRAME = 3'd2,
    SEEK_LINE  = 3'd3,
    SEEK_TAKE  = 3'd4
  } seek_state_e;
endpackage

// File: rtl/pgc_inreg.sv
module pgc_inreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fv_i,
  input  logic          lv_i,
  input  logic [DW-1:0] px_i,
  output logic          near_fv,
  output logic          near_lv,
  output logic          far_fv,
  output logic          far_lv,
  output logic [DW-1:0] far_px
);
  localparam int W     = DW + 2;
  localparam int DEPTH = 2;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [W-1:0] q;
    logic [W-1:0] d;
    if (g == 0) begin : g_head
      assign d = {fv_i, lv_i, px_i};
    end else begin : g_tail
      assign d = g_stage[g-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end

  assign near_fv = g_stage[0].q[W-1];
  assign near_lv = g_stage[0].q[W-2];
  assign far_fv  = g_stage[DEPTH-1].q[W-1];
  assign far_lv  = g_stage[DEPTH-1].q[W-2];
  assign far_px  = g_stage[DEPTH-1].q[DW-1:0];
endmodule

// File: rtl/pgc_ctrl.sv
module pgc_ctrl
  import pgc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic near_fv,
  input  logic near_lv,
  input  logic far_fv,
  input  logic far_lv,
  output logic take,
  output logic first
);
  seek_state_e st_q, st_d;
  logic        first_q, first_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEEK_OFF:   if (arm) st_d = (near_fv || near_lv) ? SEEK_DRAIN : SEEK_FRAME;
      SEEK_DRAIN: if (!near_fv && !near_lv) st_d = SEEK_FRAME;
      SEEK_FRAME: if (near_fv) st_d = near_lv ? SEEK_TAKE : SEEK_LINE;
      SEEK_LINE: begin
        if (!near_fv)     st_d = SEEK_FRAME;
        else if (near_lv) st_d = SEEK_TAKE;
      end
      SEEK_TAKE: begin
        if (!near_fv)      st_d = SEEK_FRAME;
        else if (!near_lv) st_d = SEEK_LINE;
      end
      default: st_d = SEEK_OFF;
    endcase
    if (!arm) st_d = SEEK_OFF;
  end

  assign take  = (st_q == SEEK_TAKE) && far_fv && far_lv;
  assign first = first_q;

  always_comb begin
    first_d = first_q;
    if (st_q == SEEK_FRAME && near_fv && arm) first_d = 1'b1;
    else if (take)                            first_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEEK_OFF;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      first_q <= first_d;
    end
  end
endmodule

// File: rtl/pgc_emit.sv
module pgc_emit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          first,
  input  logic          near_fv,
  input  logic          near_lv,
  input  logic [DW-1:0] far_px,
  output logic [DW-1:0] px_o,
  output logic          vld_o,
  output logic          sof_o,
  output logic          eol_o
);
  logic line_goes_on;
  assign line_goes_on = near_fv && near_lv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_o  <= '0;
      vld_o <= 1'b0;
      sof_o <= 1'b0;
      eol_o <= 1'b0;
    end else begin
      if (take) px_o <= far_px;
      vld_o <= take;
      sof_o <= take && first;
      eol_o <= take && !line_goes_on;
    end
  end
endmodule

// File: rtl/pix_gate_capture.sv
module pix_gate_capture #(
  parameter int DW = 8
) (
  input  logic          pclk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          fval_in,
  input  logic          lval_in,
  input  logic [DW-1:0] pix_in,
  output logic [DW-1:0] pix_out,
  output logic          pix_vld,
  output logic          sof_pulse,
  output logic          eol_pulse
);
  logic          near_fv, near_lv, far_fv, far_lv;
  logic [DW-1:0] far_px;
  logic          take, first;

  pgc_inreg #(.DW(DW)) u_inreg (
    .clk(pclk), .rst_n(rst_n), .fv_i(fval_in), .lv_i(lval_in), .px_i(pix_in),
    .near_fv(near_fv), .near_lv(near_lv), .far_fv(far_fv), .far_lv(far_lv),
    .far_px(far_px)
  );

  pgc_ctrl u_ctrl (
    .clk(pclk), .rst_n(rst_n), .arm(cap_en), .near_fv(near_fv), .near_lv(near_lv),
    .far_fv(far_fv), .far_lv(far_lv), .take(take), .first(first)
  );

  pgc_emit #(.DW(DW)) u_emit (
    .clk(pclk), .rst_n(rst_n), .take(take), .first(first), .near_fv(near_fv),
    .near_lv(near_lv), .far_px(far_px), .px_o(pix_out), .vld_o(pix_vld),
    .sof_o(sof_pulse), .eol_o(eol_pulse)
  );
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker #(
  parameter int DW = 8
) (
  input logic          pclk,
  input logic          rst_n,
  input logic          cap_en,
  input logic          fval_in,
  input logic          lval_in,
  input logic [DW-1:0] pix_in,
  input logic [DW-1:0] pix_out,
  input logic          pix_vld,
  input logic          sof_pulse,
  input logic          eol_pulse
);
  assert_gated_R2: assert property (@(posedge pclk) disable iff (!rst_n)
    pix_vld |-> ($past(fval_in, 3) && $past(lval_in, 3)));

  assert_byte_match_R3: assert property (@(posedge pclk) disable iff (!rst_n)
    pix_vld |-> (pix_out == $past(pix_in, 3)));

  assert_sof_strobed_R5: assert property (@(posedge pclk) disable iff (!rst_n)
    sof_pulse |-> pix_vld);

  assert_eol_strobed_R6: assert property (@(posedge pclk) disable iff (!rst_n)
    eol_pulse |-> pix_vld);

  assert_eol_lookahead_R6: assert property (@(posedge pclk) disable iff (!rst_n)
    eol_pulse |-> !($past(fval_in, 2) && $past(lval_in, 2)));

  assert_line_contiguous_R3: assert property (@(posedge pclk) disable iff (!rst_n)
    (pix_vld && !eol_pulse && $past(cap_en)) |=> pix_vld);

  assert_enable_gate_R7: assert property (@(posedge pclk) disable iff (!rst_n)
    pix_vld |-> $past(cap_en, 2));
endmodule

bind pix_gate_capture pgc_checker #(.DW(DW)) i_pgc_checker (
  .pclk(pclk), .rst_n(rst_n), .cap_en(cap_en), .fval_in(fval_in),
  .lval_in(lval_in), .pix_in(pix_in), .pix_out(pix_out), .pix_vld(pix_vld),
  .sof_pulse(sof_pulse), .eol_pulse(eol_pulse)
);

// File: tb/test_pix_gate_capture.sv
`timescale 1ns/1ps
module test_pix_gate_capture;
  localparam int XN = 8192;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cap_en = 1'b0;
  logic       fv = 1'b0;
  logic       lv = 1'b0;
  logic [7:0] px = 8'h10;
  logic [7:0] pix_out;
  logic       pix_vld, sof_pulse, eol_pulse;

  pix_gate_capture i_pix_gate_capture (
    .pclk(clk), .rst_n(rst_n), .cap_en(cap_en), .fval_in(fv), .lval_in(lv),
    .pix_in(px), .pix_out(pix_out), .pix_vld(pix_vld), .sof_pulse(sof_pulse),
    .eol_pulse(eol_pulse)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic       ex_v [XN];
  logic       ex_f [XN];
  logic       ex_l [XN];
  logic [7:0] ex_d [XN];
  int n_chk = 0, n_bad = 0, n_bytes = 0, mi = 0;
  bit mon_on = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: expectation for each cycle, written by the drivers
  always @(negedge clk) begin
    if (mon_on) begin
      mi = cyc % XN;
      chk(pix_vld == ex_v[mi], ex_v[mi] ? "R3 missing byte" : "R2 unexpected byte",
          int'(pix_vld), int'(ex_v[mi]));
      if (ex_v[mi] && pix_vld) begin
        chk(pix_out == ex_d[mi], "R3 data", int'(pix_out), int'(ex_d[mi]));
        chk(pix_out != 8'h10, "R2 blanking value", int'(pix_out), 0);
        chk(sof_pulse == ex_f[mi], "R5 frame start", int'(sof_pulse), int'(ex_f[mi]));
        chk(eol_pulse == ex_l[mi], "R6 line end", int'(eol_pulse), int'(ex_l[mi]));
      end
      if (pix_vld) n_bytes++;
      ex_v[mi] = 1'b0;
      ex_f[mi] = 1'b0;
      ex_l[mi] = 1'b0;
    end
  end

  // one sample; a byte driven here is expected three negedges later
  task automatic put(input bit f, input bit l, input logic [7:0] d,
                     input bit ecap, input bit efirst, input bit elast);
    int k;
    @(negedge clk);
    fv = f; lv = l; px = d;
    k = (cyc + 3) % XN;
    ex_v[k] = ecap; ex_f[k] = efirst; ex_l[k] = elast; ex_d[k] = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic frame(input int nl, input int len, input int gap, input bit cap,
                       input bit together, input int arm_line, input logic [7:0] seed);
    for (int ln = 0; ln < nl; ln++) begin
      if (ln == arm_line) cap_en = 1'b1;
      if (ln > 0 || !together)
        for (int g = 0; g < gap; g++) put(1'b1, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < len; i++)
        put(1'b1, 1'b1, {1'b1, 7'(seed + ln * 8 + i)}, cap,
            cap && ln == 0 && i == 0, cap && i == len - 1);
    end
    put(1'b1, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0);
    idle(3);
  endtask

  task automatic count_since(input int base, input int exp, input string tag);
    idle(4);
    chk((n_bytes - base) == exp, tag, n_bytes - base, exp);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    int base, total;
    for (int i = 0; i < XN; i++) begin
      ex_v[i] = 1'b0; ex_f[i] = 1'b0; ex_l[i] = 1'b0; ex_d[i] = 8'h00;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pix_vld == 1'b0 && sof_pulse == 1'b0 && eol_pulse == 1'b0,
        "R1 reset strobes", {pix_vld, sof_pulse, eol_pulse}, 0);
    chk(pix_out == 8'h00, "R1 reset data", int'(pix_out), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R7: disabled capture ignores a whole frame
    base = n_bytes;
    frame(2, 4, 2, 1'b0, 1'b0, -1, 8'h03);
    count_since(base, 0, "R7 bytes while disabled");

    // R3/R5/R6 sweep over line count, line length and gap
    cap_en = 1'b1;
    idle(2);
    base = n_bytes; total = 0;
    for (int nl = 1; nl <= 4; nl++)
      for (int len = 1; len <= 6; len++)
        for (int gap = 1; gap <= 2; gap++) begin
          frame(nl, len, gap, 1'b1, 1'b0, -1, 8'(nl * 37 + len * 5 + gap));
          total += nl * len;
        end
    count_since(base, total, "R3 sweep byte total");

    // R8: both qualifiers rise together
    base = n_bytes;
    frame(2, 3, 2, 1'b1, 1'b1, -1, 8'h51);
    frame(1, 1, 1, 1'b1, 1'b1, -1, 8'h22);
    count_since(base, 7, "R8 bytes with joint rise");

    // R4: enable raised mid-frame; that frame is skipped, next one taken
    cap_en = 1'b0;
    idle(2);
    base = n_bytes;
    frame(3, 4, 2, 1'b0, 1'b0, 1, 8'h11);
    count_since(base, 0, "R4 bytes of joined frame");
    base = n_bytes;
    frame(2, 3, 2, 1'b1, 1'b0, -1, 8'h44);
    count_since(base, 6, "R4 bytes of next frame");

    // R4: enable raised while the line qualifier is high
    cap_en = 1'b0;
    idle(2);
    base = n_bytes;
    put(1'b1, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0);
    put(1'b1, 1'b1, 8'hA0, 1'b0, 1'b0, 1'b0);
    cap_en = 1'b1;
    for (int i = 1; i < 4; i++) put(1'b1, 1'b1, 8'(8'hA0 + i), 1'b0, 1'b0, 1'b0);
    put(1'b1, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0);
    idle(3);
    count_since(base, 0, "R4 bytes after mid-line enable");

    // R9: frame qualifier falls while the line qualifier stays high
    base = n_bytes;
    put(1'b1, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0);
    put(1'b1, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0);
    put(1'b1, 1'b1, 8'hC1, 1'b1, 1'b1, 1'b0);
    put(1'b1, 1'b1, 8'hC2, 1'b1, 1'b0, 1'b0);
    put(1'b1, 1'b1, 8'hC3, 1'b1, 1'b0, 1'b1);
    put(1'b0, 1'b1, 8'hC4, 1'b0, 1'b0, 1'b0);
    put(1'b0, 1'b1, 8'hC5, 1'b0, 1'b0, 1'b0);
    idle(3);
    frame(2, 2, 1, 1'b1, 1'b0, -1, 8'h66);
    count_since(base, 7, "R9 bytes around early frame end");

    // R7: disabled again
    cap_en = 1'b0;
    idle(2);
    base = n_bytes;
    frame(3, 5, 1, 1'b0, 1'b0, -1, 8'h07);
    count_since(base, 0, "R7 bytes after disable");

    done = 1'b1;
    report();
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end
endmodule